// File: doc/BRIEF.md
# Parallel display bus controller

This block drives a parallel write/read bus toward an external display controller. A host fills an eight-entry buffer through a small register interface, programs how many bus beats to issue, and the block unpacks each buffered 32-bit word into 8-bit or 16-bit beats. Every beat shows the command/data select level, a chip select level, and a write or read strobe whose low time and beat length are counted in ticks of a divided clock.

Strobe timing comes from three control fields: a tick divider (1 to 8 clock cycles per tick), a strobe-active length (1 to 16 ticks) and a beat length (up to 64 ticks). All three are stored as value minus one. Programming a beat length below three ticks makes the block reset itself. In read mode the block issues read strobes and packs the sampled bus values into a word the host can read. When DMA mode is on, a request line asks an external engine to fill the buffer while a transfer is running.

Top module: `lcd_pbus_ctrl`

## Requirements
- R1: After reset `cs_n`, `wr_n` and `rd_n` are 1, `dma_req` is 0, the status word (address 1) reads bit0=1 with buffer level 0 in bits [11:8], and the control word (address 0) reads 0x31.
- R2: The control word at address 0 holds `act_m1` in bits [3:0], `cyc_m1` in [9:4] and `div_m1` in [12:10]. With tick = `div_m1`+1 clocks, a strobe stays low for min(`act_m1`+1, `cyc_m1`) ticks of a beat lasting `cyc_m1`+1 ticks.
- R3: With control bit 17 (`wide`) at 0, a buffered word gives 4 beats with its bytes sent least significant first on `bus_dout[7:0]`, and `bus_dout[15:8]` at 0. With `wide` at 1, it gives 2 beats: the low halfword first, then the high halfword.
- R4: Writing N to address 1 (bits [17:0]) starts a transfer of exactly N+1 beats. If the count ends partway through a word, the rest of that word is discarded.
- R5: `dc` follows control bit 13: 0 marks a command and 1 marks data.
- R6: `cs_n` is the inverse of control bit 14 (`sel`). Write beats advance only while `sel`=1 and control bit 15 (the write-strobe enable) is 1. Otherwise no strobe appears and the buffer is left untouched.
- R7: A host write to address 2 pushes one entry. `h_size` 0 means a byte, 1 a halfword, and 2 or 3 a full word, and the data is taken from the low lanes. An entry yields (bytes / bus bytes) beats, with a minimum of 1.
- R8: Status bit0 reads 1 exactly when the buffer is empty and no transfer is in progress.
- R9: `dma_req` is 1 while control bit 16 (DMA enable) is 1, a write transfer is in progress and the buffer is not full. Otherwise it is 0.
- R10: Writing the control word with `cyc_m1` < 2 resets the block. The buffer empties, any transfer stops, and the control word returns to 0x31.
- R11: With control bit 18 (`rd_mode`) at 1, beats pulse `rd_n` instead of `wr_n`. `bus_din` is sampled on the clock edge that ends each strobe, and the samples are packed least significant first into the word read at address 2.
- R12: The buffer holds 8 entries. A push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_addr | input | 2 | Register address: 0 control, 1 count (write) / status (read), 2 buffer (write) / read word (read) |
| h_size | input | 2 | Access size for buffer writes |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| dc | output | 1 | Command (0) / data (1) select |
| bus_dout | output | 16 | Beat data toward the display |
| bus_din | input | 16 | Data returned by the display in read mode |
| dma_req | output | 1 | Request for buffer fill by a DMA engine |

## Verification
The bench checks that every beat's byte order and zero-extended upper lane are correct. If the unpacking were wrong, the beats would come out in the wrong order or carry stale upper bits. It sends a count that ends in the middle of a word and checks that no extra beat appears and that the leftover word is not kept in the buffer. It measures strobe low time in clock cycles, including the case where the active field is longer than the beat; a design that did not clip the strobe there would leave the strobe low across beats. It fills the buffer past full with the strobe disabled, checks that the DMA request falls and the level sticks at 8, and then triggers a self-reset through a short beat length. It also checks that read beats are packed in order.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int BUS_W = 16;

  typedef struct packed {
    logic       rd_mode;
    logic       wide;
    logic       dma_en;
    logic       wr_en;
    logic       sel;
    logic       dc;
    logic [2:0] div_m1;
    logic [5:0] cyc_m1;
    logic [3:0] act_m1;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RST = 19'h00031;

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] word;
  } fifo_ent_t;

  // beats one buffered entry produces
  function automatic logic [2:0] ent_beats(logic [1:0] size, logic wide);
    case (size)
      2'd0:    return 3'd1;
      2'd1:    return wide ? 3'd1 : 3'd2;
      default: return wide ? 3'd2 : 3'd4;
    endcase
  endfunction

  // beat value for position idx of a word
  function automatic logic [BUS_W-1:0] beat_slice(logic [31:0] w, logic [1:0] idx, logic wide);
    if (wide) return idx[0] ? w[31:16] : w[15:0];
    return {8'h00, w[{idx, 3'b000} +: 8]};
  endfunction

  // insert a sampled read beat into the packing word
  function automatic logic [31:0] pack_beat(logic [31:0] acc, logic [BUS_W-1:0] din,
                                            logic [1:0] idx, logic wide);
    logic [31:0] r;
    r = acc;
    if (wide) begin
      if (idx[0]) r[31:16] = din;
      else        r[15:0]  = din;
    end else begin
      r[{idx, 3'b000} +: 8] = din[7:0];
    end
    return r;
  endfunction

  // last tick index (0-based) with the strobe active, clipped inside the beat
  function automatic logic [5:0] strobe_last(logic [3:0] act_m1, logic [5:0] cyc_m1);
    if ({2'b00, act_m1} < cyc_m1) return {2'b00, act_m1};
    return cyc_m1 - 6'd1;
  endfunction

endpackage

// File: rtl/pbus_tick.sv
module pbus_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pbus_fifo.sv
module pbus_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  p_pop_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/pbus_beat_engine.sv
module pbus_beat_engine
  import pbus_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  ctrl_t            ctrl,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             tick,
  input  logic             fifo_empty,
  input  fifo_ent_t        head,
  input  logic [BUS_W-1:0] bus_din,
  output logic             pop,
  output logic             busy,
  output logic             in_beat,
  output logic             strobe_on,
  output logic [BUS_W-1:0] bus_dout,
  output logic [31:0]      rd_word
);
  logic [CNT_W:0] remaining;
  logic [5:0]     tcnt;
  logic [1:0]     sub;
  logic [31:0]    acc;
  logic [5:0]     act_last;
  logic [2:0]     nbeats;
  logic           run, ready, beat_start, beat_end, last_sub, last_beat, rd_capture;
  logic [31:0]    acc_next;

  assign run        = ctrl.sel && (ctrl.rd_mode || ctrl.wr_en);
  assign ready      = busy && run && (ctrl.rd_mode || !fifo_empty);
  assign beat_start = tick && !in_beat && ready;
  assign beat_end   = tick && in_beat && (tcnt == ctrl.cyc_m1);
  assign act_last   = strobe_last(ctrl.act_m1, ctrl.cyc_m1);
  assign strobe_on  = in_beat && (tcnt <= act_last);
  assign nbeats     = ctrl.rd_mode ? (ctrl.wide ? 3'd2 : 3'd4) : ent_beats(head.size, ctrl.wide);
  assign last_sub   = ({1'b0, sub} == nbeats - 3'd1);
  assign last_beat  = (remaining == (CNT_W+1)'(1));
  assign pop        = beat_end && !ctrl.rd_mode && (last_sub || last_beat);
  assign rd_capture = tick && in_beat && ctrl.rd_mode && (tcnt == act_last);
  assign acc_next   = pack_beat(acc, bus_din, sub, ctrl.wide);
  assign bus_dout   = ctrl.rd_mode ? '0 : beat_slice(head.word, sub, ctrl.wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; remaining <= '0; in_beat <= 1'b0; tcnt <= '0;
      sub <= '0; acc <= '0; rd_word <= '0;
    end else if (clr) begin
      busy <= 1'b0; remaining <= '0; in_beat <= 1'b0; tcnt <= '0;
      sub <= '0; acc <= '0; rd_word <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      remaining <= {1'b0, start_cnt} + 1'b1;
      in_beat   <= 1'b0;
      tcnt      <= '0;
      sub       <= '0;
      acc       <= '0;
    end else begin
      if (beat_start) begin
        in_beat <= 1'b1;
        tcnt    <= '0;
      end else if (beat_end) begin
        in_beat   <= 1'b0;
        remaining <= remaining - 1'b1;
        if (last_beat) busy <= 1'b0;
        sub <= (last_sub || last_beat) ? 2'd0 : sub + 2'd1;
      end else if (tick && in_beat) begin
        tcnt <= tcnt + 6'd1;
      end
      if (rd_capture) begin
        if (last_sub || last_beat) begin
          rd_word <= acc_next;
          acc     <= '0;
        end else begin
          acc <= acc_next;
        end
      end
    end
  end

  p_beat_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_beat) |-> $past(ctrl.sel && (ctrl.rd_mode || !fifo_empty)));
  p_count_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start) && !$past(clr) && remaining != $past(remaining)) |-> $past(beat_end));
endmodule

// File: rtl/lcd_pbus_ctrl.sv
module lcd_pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 18,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [1:0]        h_addr,
  input  logic [1:0]        h_size,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              cs_n,
  output logic              wr_n,
  output logic              rd_n,
  output logic              dc,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic [BUS_W-1:0]  bus_din,
  output logic              dma_req
);
  ctrl_t       ctrl_q;
  fifo_ent_t   push_ent, head;
  logic        wr_ctrl, soft_rst, start, push, pop;
  logic        tick, fifo_empty, fifo_full, busy, in_beat, strobe_on, xfer_done;
  logic [LW-1:0] level;
  logic [31:0] rd_word, push_data;

  assign wr_ctrl  = h_wr && (h_addr == 2'd0);
  assign soft_rst = wr_ctrl && (h_wdata[9:4] < 6'd2);
  assign start    = h_wr && (h_addr == 2'd1);
  assign push     = h_wr && (h_addr == 2'd2);

  always_comb begin
    case (h_size)
      2'd0:    push_data = {24'h0, h_wdata[7:0]};
      2'd1:    push_data = {16'h0, h_wdata[15:0]};
      default: push_data = h_wdata;
    endcase
  end
  assign push_ent = '{size: h_size, word: push_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= ctrl_t'(CTRL_RST);
    else if (soft_rst) ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_ctrl)  ctrl_q <= ctrl_t'(h_wdata[CTRL_W-1:0]);
  end

  pbus_tick #(.DIV_W(3)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .div_m1(ctrl_q.div_m1), .tick(tick)
  );

  pbus_fifo #(.W($bits(fifo_ent_t)), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(push), .din(push_ent),
    .pop(pop), .dout(head), .empty(fifo_empty), .full(fifo_full), .level(level)
  );

  pbus_beat_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .ctrl(ctrl_q),
    .start(start), .start_cnt(h_wdata[CNT_W-1:0]), .tick(tick),
    .fifo_empty(fifo_empty), .head(head), .bus_din(bus_din),
    .pop(pop), .busy(busy), .in_beat(in_beat), .strobe_on(strobe_on),
    .bus_dout(bus_dout), .rd_word(rd_word)
  );

  assign xfer_done = fifo_empty && !busy;
  assign cs_n      = !ctrl_q.sel;
  assign dc        = ctrl_q.dc;
  assign wr_n      = !(strobe_on && ctrl_q.sel && ctrl_q.wr_en && !ctrl_q.rd_mode);
  assign rd_n      = !(strobe_on && ctrl_q.sel && ctrl_q.rd_mode);
  assign dma_req   = ctrl_q.dma_en && busy && !ctrl_q.rd_mode && !fifo_full;

  always_comb begin
    h_rdata = '0;
    case (h_addr)
      2'd0: h_rdata[CTRL_W-1:0] = ctrl_q;
      2'd1: begin
        h_rdata[0]       = xfer_done;
        h_rdata[8 +: LW] = level;
      end
      2'd2: h_rdata = rd_word;
      default: h_rdata = '0;
    endcase
  end

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !cs_n);
  p_dma_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !dma_req);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (wr_n && rd_n));
endmodule

// File: tb/lcd_pbus_ctrl_test.sv
module lcd_pbus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0;
  logic [1:0]  h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        cs_n, wr_n, rd_n, dc, dma_req;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 16'h1234;

  int checks = 0;
  int failures = 0;
  int beats_seen = 0;
  int rd_pulses = 0;
  int exp_w = 0;
  bit finished = 0;
  bit cur_wide = 0;
  bit cur_dc = 0;
  logic [16:0] expq[$];

  always #10 clk = ~clk;

  lcd_pbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_size(h_size),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .dc(dc), .bus_dout(bus_dout), .bus_din(bus_din), .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkctrl(int act, int cyc, int dv, bit dcb, bit sel,
                                         bit wen, bit dma, bit wide, bit rd);
    logic [31:0] c;
    c = '0;
    c[3:0] = act[3:0]; c[9:4] = cyc[5:0]; c[12:10] = dv[2:0];
    c[13] = dcb; c[14] = sel; c[15] = wen; c[16] = dma; c[17] = wide; c[18] = rd;
    return c;
  endfunction

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d; h_size = s;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] r);
    @(negedge clk);
    h_addr = a;
    #1 r = h_rdata;
  endtask

  // driver: push a buffer entry and queue the beats it should produce
  task automatic push_word(input logic [31:0] w, input logic [1:0] s, input int take);
    int nbytes, n;
    logic [31:0] m;
    nbytes = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    m = (s == 0) ? (w & 32'hFF) : (s == 1) ? (w & 32'hFFFF) : w;
    n = cur_wide ? ((nbytes >= 2) ? nbytes / 2 : 1) : nbytes;
    for (int i = 0; i < n && i < take; i++) begin
      if (cur_wide) expq.push_back({cur_dc, m[16*i +: 16]});
      else          expq.push_back({cur_dc, 8'h00, m[8*i +: 8]});
    end
    hwrite(2'd2, w, s);
  endtask

  task automatic wait_done;
    logic [31:0] st;
    for (int i = 0; i < 3000; i++) begin
      hread(2'd1, st);
      if (st[0]) break;
    end
  endtask

  // monitor: compare each write beat when its strobe rises
  bit prev_wr = 1'b1;
  int low_cnt = 0;
  logic [15:0] last_data;
  logic last_dc;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!wr_n) begin
        low_cnt++;
        last_data = bus_dout;
        last_dc = dc;
      end else if (!prev_wr) begin
        beats_seen++;
        if (expq.size() == 0) begin
          check("R4 unexpected beat", {15'h0, last_dc, last_data}, 32'hFFFFFFFF);
        end else begin
          logic [16:0] e;
          e = expq.pop_front();
          check("R3 R5 beat data/dc", {15'h0, last_dc, last_data}, {15'h0, e});
          if (exp_w != 0) check("R2 strobe width", low_cnt, exp_w);
        end
        low_cnt = 0;
      end
      prev_wr = wr_n;
    end
  end

  // read responder: new bus value after each read strobe
  bit prev_rd = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_n && !prev_rd) begin
        rd_pulses++;
        bus_din = (rd_pulses == 1) ? 16'h5678 : 16'h9ABC;
      end
      prev_rd = rd_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", cs_n, 1);
    check("R1 wr_n", wr_n, 1);
    check("R1 rd_n", rd_n, 1);
    check("R1 dma_req", dma_req, 0);
    hread(2'd1, r); check("R1 status", r, 32'h1);
    hread(2'd0, r); check("R1 ctrl", r, 32'h31);

    // R3 R2 R5 R4 R8: 8-bit data beats, div 2
    cur_wide = 0; cur_dc = 1; exp_w = 4;
    hwrite(2'd0, mkctrl(1, 3, 1, 1, 1, 1, 0, 0, 0), 2);
    push_word(32'h44332211, 2'd2, 4);
    hread(2'd1, r); check("R8 not done with data", r[0], 0);
    b0 = beats_seen;
    hwrite(2'd1, 32'd3, 2);
    check("R9 no dma when disabled", dma_req, 0);
    wait_done;
    check("R4 four beats", beats_seen - b0, 4);
    check("R4 queue drained", expq.size(), 0);
    hread(2'd1, r); check("R8 done", r, 32'h1);

    // R3 R5 R7: 16-bit command beats, then a byte entry
    cur_wide = 1; cur_dc = 0; exp_w = 4;
    hwrite(2'd0, mkctrl(1, 3, 1, 0, 1, 1, 0, 1, 0), 2);
    push_word(32'hBEEFCAFE, 2'd2, 4);
    push_word(32'hFFFFFF77, 2'd0, 4);
    b0 = beats_seen;
    hwrite(2'd1, 32'd2, 2);
    wait_done;
    check("R7 three wide beats", beats_seen - b0, 3);

    // R7: halfword and byte on 8-bit bus
    cur_wide = 0; cur_dc = 1; exp_w = 4;
    hwrite(2'd0, mkctrl(1, 3, 1, 1, 1, 1, 0, 0, 0), 2);
    push_word(32'h9999ABCD, 2'd1, 4);
    push_word(32'h0000005A, 2'd0, 4);
    b0 = beats_seen;
    hwrite(2'd1, 32'd2, 2);
    wait_done;
    check("R7 narrow entries", beats_seen - b0, 3);

    // R4: count ends inside a word
    push_word(32'h88776655, 2'd2, 2);
    b0 = beats_seen;
    hwrite(2'd1, 32'd1, 2);
    wait_done;
    repeat (20) @(negedge clk);
    check("R4 truncated beats", beats_seen - b0, 2);
    hread(2'd1, r); check("R4 leftover discarded", r[11:8], 0);

    // R2 clipping: act longer than beat, div 1
    exp_w = 3;
    hwrite(2'd0, mkctrl(5, 3, 0, 1, 1, 1, 0, 0, 0), 2);
    push_word(32'h000000C3, 2'd0, 4);
    hwrite(2'd1, 32'd0, 2);
    wait_done;

    // R6: write strobe disabled
    exp_w = 4;
    hwrite(2'd0, mkctrl(1, 3, 1, 1, 1, 0, 0, 0, 0), 2);
    push_word(32'hA1B2C3D4, 2'd2, 1);
    b0 = beats_seen;
    hwrite(2'd1, 32'd0, 2);
    repeat (40) @(negedge clk);
    check("R6 no beats when disabled", beats_seen - b0, 0);
    hread(2'd1, r); check("R6 buffer untouched", r[11:8], 1);
    check("R6 cs asserted", cs_n, 0);
    hwrite(2'd0, mkctrl(1, 3, 1, 1, 1, 1, 0, 0, 0), 2);
    wait_done;
    check("R6 beat after enable", beats_seen - b0, 1);
    hwrite(2'd0, mkctrl(1, 3, 1, 1, 0, 1, 0, 0, 0), 2);
    @(negedge clk);
    check("R6 cs released", cs_n, 1);

    // R9 R12 R10: DMA request, overflow, self reset
    hwrite(2'd0, mkctrl(1, 3, 1, 1, 1, 0, 1, 0, 0), 2);
    hwrite(2'd1, 32'd1, 2);
    @(negedge clk);
    check("R9 dma requested", dma_req, 1);
    for (int i = 0; i < 8; i++) hwrite(2'd2, 32'h100 + i, 2);
    @(negedge clk);
    check("R9 dma drops when full", dma_req, 0);
    hread(2'd1, r); check("R12 level full", r[11:8], 8);
    hwrite(2'd2, 32'hDEAD, 2);
    hread(2'd1, r); check("R12 push dropped", r[11:8], 8);
    hwrite(2'd0, mkctrl(1, 1, 1, 1, 1, 1, 1, 0, 0), 2);
    hread(2'd1, r); check("R10 buffer cleared", r, 32'h1);
    hread(2'd0, r); check("R10 ctrl default", r, 32'h31);
    check("R10 dma idle", dma_req, 0);
    check("R10 cs released", cs_n, 1);

    // R11: read mode, 16-bit, two beats
    b0 = beats_seen;
    hwrite(2'd0, mkctrl(0, 2, 0, 1, 1, 0, 0, 1, 1), 2);
    hwrite(2'd1, 32'd1, 2);
    wait_done;
    hread(2'd2, r); check("R11 read word", r, 32'h56781234);
    check("R11 read strobes", rd_pulses, 2);
    check("R11 no write beats", beats_seen - b0, 0);

    check("R3 queue empty at end", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule